// File: doc/BRIEF.md
# Formatted Capture Data Buffer

This block stores converter results in a sixteen-entry memory of 16-bit words. Each accepted result is packed with a selectable tag layout before it is stored: the 12-bit result always occupies the upper bits. The lower four bits hold either zeros, a 3-bit channel number with a zero, or a channel number with a set data-valid bit. The oldest stored word is always shown on the read port. A pop pulse removes it.

A capture mode decides which samples are kept relative to a trigger pulse, such as an alert or a stop event. In the two linear modes (start-burst, post-alert) nothing is stored until the trigger arrives. Storing then stops once the buffer holds sixteen words. In the two ring modes (stop-burst, pre-alert) storing begins as soon as the mode is entered. When full, each new word overwrites the oldest, and the trigger freezes the contents. The two modes in each pair behave the same; they differ only in what drives the trigger. Any change of the mode code flushes the buffer and re-arms it for the new mode.

Top module: `capture_buf`

## Requirements
- R1: After reset the count is 0, the full flag is low and the read word is 0. The mode register starts at start-burst (001), so results offered before a trigger are not stored.
- R2: The word holds the result in bits [15:4]. With format code 00 or 11, bits [3:0] are zero.
- R3: With format code 01, bits [3:1] hold the channel number (000 for channel 0, 001 for channel 1) and bit [0] is zero.
- R4: With format code 10, bits [3:1] hold the channel number and bit [0], the data-valid bit, is one.
- R5: In start-burst (001) and post-alert (110), results are dropped until the trigger. The result offered in the trigger cycle and those after it are stored.
- R6: In the linear modes, storing stops at 16 entries. The full flag is high and later results are dropped.
- R7: In stop-burst (000) and pre-alert (100), storing starts when the mode is entered. When full, a new result overwrites the oldest entry and the count stays 16.
- R8: In the ring modes, the trigger freezes the buffer. The result offered in the trigger cycle is kept and later results are dropped.
- R9: The read port shows the oldest entry. A pop removes it, and the count drops by one on the next clock.
- R10: When the buffer is empty the read word is 0, so its data-valid bit is clear. A pop has no effect on the count.
- R11: A change of the mode code flushes the buffer to count 0 in one clock and drops the inputs of that cycle. Reserved codes (010, 011, 101, 111) store nothing.
- R12: A pop and a stored result in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Result strobe |
| res_data_i | input | 12 | Conversion result |
| res_chan_i | input | 3 | Channel number of the result |
| fmt_i | input | 2 | Word format code |
| mode_i | input | 3 | Capture mode code |
| trig_i | input | 1 | Trigger pulse (alert or stop event) |
| pop_i | input | 1 | Remove the oldest entry |
| rd_data_o | output | 16 | Oldest entry, or 0 when empty |
| count_o | output | 5 | Number of stored entries, 0 to 16 |
| full_o | output | 1 | Buffer holds 16 entries |

## Verification
The bench builds the block with its default parameters: 16 entries, 12-bit results and 3-bit channel numbers. Because the depth is small, a few dozen strobes are enough to overfill the buffer in every mode. That exposes the stop at 16 in the linear modes and the overwrite-then-freeze ordering in the ring modes. The default widths let each of the four format codes be recognised bit by bit in the low nibble.

// File: rtl/cbuf_pkg.sv
`timescale 1ns/1ps
package cbuf_pkg;
  localparam logic [2:0] MODE_STOP_BURST  = 3'b000;
  localparam logic [2:0] MODE_START_BURST = 3'b001;
  localparam logic [2:0] MODE_PRE_ALERT   = 3'b100;
  localparam logic [2:0] MODE_POST_ALERT  = 3'b110;

  localparam logic [1:0] FMT_PLAIN   = 2'b00;
  localparam logic [1:0] FMT_CHAN    = 2'b01;
  localparam logic [1:0] FMT_CHAN_DV = 2'b10;

  // ring modes overwrite and freeze on trigger
  function automatic logic is_ring(input logic [2:0] m);
    return (m == MODE_STOP_BURST) || (m == MODE_PRE_ALERT);
  endfunction

  // linear modes start on trigger and stop when full
  function automatic logic is_linear(input logic [2:0] m);
    return (m == MODE_START_BURST) || (m == MODE_POST_ALERT);
  endfunction
endpackage

// File: rtl/cbuf_pack.sv
`timescale 1ns/1ps
module cbuf_pack #(
  parameter int RES_W  = 12,
  parameter int CHID_W = 3
) (
  input  logic [RES_W-1:0]        res_i,
  input  logic [CHID_W-1:0]       chan_i,
  input  logic [1:0]              fmt_i,
  output logic [RES_W+CHID_W:0]   word_o
);
  import cbuf_pkg::*;

  always_comb begin
    unique case (fmt_i)
      FMT_CHAN:    word_o = {res_i, chan_i, 1'b0};
      FMT_CHAN_DV: word_o = {res_i, chan_i, 1'b1};
      default:     word_o = {res_i, {(CHID_W+1){1'b0}}};
    endcase
  end
endmodule

// File: rtl/cbuf_ctrl.sv
`timescale 1ns/1ps
module cbuf_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       trig_i,
  input  logic       res_valid_i,
  input  logic       full_i,
  output logic       flush_o,
  output logic       ring_o,
  output logic       wr_en_o
);
  import cbuf_pkg::*;

  logic [2:0] mode_q;
  logic       cap_q;
  logic       lin_cur;

  assign flush_o = (mode_i != mode_q);
  assign ring_o  = is_ring(mode_q);
  assign lin_cur = is_linear(mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_START_BURST;
      cap_q  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (flush_o) begin
        cap_q <= is_ring(mode_i);
      end else if (lin_cur) begin
        if (trig_i && !full_i) cap_q <= 1'b1;
        else if (full_i)       cap_q <= 1'b0;
      end else if (ring_o && trig_i) begin
        cap_q <= 1'b0;
      end
    end
  end

  // trigger-cycle sample is kept in both families
  assign wr_en_o = res_valid_i && !flush_o &&
                   ((ring_o && cap_q) || (lin_cur && (cap_q || trig_i)));

  // R8
  ring_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_o && trig_i && !flush_o) |=> !wr_en_o);
endmodule

// File: rtl/cbuf_store.sv
`timescale 1ns/1ps
module cbuf_store #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         wr_en_i,
  input  logic [WORD_W-1:0]            wr_word_i,
  input  logic                         ring_i,
  input  logic                         pop_i,
  output logic [WORD_W-1:0]            rd_word_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;
  logic              empty, full, do_pop, do_wr, drop_head;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (count_q == '0);
  assign full      = (count_q == FULL_CNT);
  assign do_pop    = pop_i && !empty && !flush_i;
  assign do_wr     = wr_en_i && !flush_i && (!full || ring_i || do_pop);
  // overwrite when full without a pop drops the oldest
  assign drop_head = do_pop || (do_wr && full);

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[tail_q] <= wr_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_wr)     tail_q <= nxt(tail_q);
      if (drop_head) head_q <= nxt(head_q);
      count_q <= count_q + CNT_W'(do_wr) - CNT_W'(drop_head && !(do_wr && full && !do_pop) ? 1'b1 : (do_wr && full && !do_pop));
    end
  end

  assign rd_word_o = empty ? '0 : mem_q[head_q];
  assign count_o   = count_q;
  assign full_o    = full;

  // R6
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);
  // R9
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1) ||
                 (count_q + 1'b1 == $past(count_q)));
  // R10
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && !wr_en_i) |=> (count_q == '0));
  // R7
  ring_keep_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && wr_en_i && ring_i && !flush_i) |=> full_o);
  // R12
  pop_wr_same_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_pop && do_wr) |=> $stable(count_q));
  // R11
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0));
endmodule

// File: rtl/capture_buf.sv
`timescale 1ns/1ps
module capture_buf #(
  parameter int DEPTH  = 16,
  parameter int RES_W  = 12,
  parameter int CHID_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        res_valid_i,
  input  logic [RES_W-1:0]            res_data_i,
  input  logic [CHID_W-1:0]           res_chan_i,
  input  logic [1:0]                  fmt_i,
  input  logic [2:0]                  mode_i,
  input  logic                        trig_i,
  input  logic                        pop_i,
  output logic [RES_W+CHID_W:0]       rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0]  count_o,
  output logic                        full_o
);
  localparam int WORD_W = RES_W + CHID_W + 1;

  logic [WORD_W-1:0] packed_word;
  logic              flush, ring, wr_en;

  cbuf_pack #(.RES_W(RES_W), .CHID_W(CHID_W)) u_pack (
    .res_i  (res_data_i),
    .chan_i (res_chan_i),
    .fmt_i  (fmt_i),
    .word_o (packed_word)
  );

  cbuf_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .trig_i      (trig_i),
    .res_valid_i (res_valid_i),
    .full_i      (full_o),
    .flush_o     (flush),
    .ring_o      (ring),
    .wr_en_o     (wr_en)
  );

  cbuf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush),
    .wr_en_i   (wr_en),
    .wr_word_i (packed_word),
    .ring_i    (ring),
    .pop_i     (pop_i),
    .rd_word_o (rd_data_o),
    .count_o   (count_o),
    .full_o    (full_o)
  );

  // R10
  empty_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> (rd_data_o == '0));
endmodule

// File: tb/capture_buf_bench.sv
`timescale 1ns/1ps
module capture_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [11:0] res_data = '0;
  logic [2:0]  res_chan = '0;
  logic [1:0]  fmt = 2'b00;
  logic [2:0]  mode = 3'b001;
  logic        trig = 1'b0;
  logic        pop = 1'b0;
  logic [15:0] rd_data;
  logic [4:0]  count;
  logic        full;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  capture_buf u_capture_buf (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(res_valid), .res_data_i(res_data),
    .res_chan_i(res_chan), .fmt_i(fmt), .mode_i(mode), .trig_i(trig),
    .pop_i(pop), .rd_data_o(rd_data), .count_o(count), .full_o(full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] v, input logic [2:0] ch, input logic tg, input logic pp);
    res_valid = 1'b1; res_data = v; res_chan = ch; trig = tg; pop = pp;
    @(negedge clk);
    res_valid = 1'b0; trig = 1'b0; pop = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [15:0] exp);
    chk(req, rd_data, exp);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    mode = m;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 count", count, 0);
    chk("R1 full", full, 0);
    chk("R1 rd", rd_data, 0);
    push(12'h555, 3'd0, 1'b0, 1'b0);
    push(12'h556, 3'd0, 1'b0, 1'b0);
    chk("R1 R5 no store before trigger", count, 0);
  endtask

  task automatic t_formats;
    fmt = 2'b00; push(12'hABC, 3'd1, 1'b1, 1'b0);
    chk("R5 trigger sample stored", count, 1);
    fmt = 2'b01; push(12'h123, 3'd1, 1'b0, 1'b0);
    fmt = 2'b10; push(12'h456, 3'd1, 1'b0, 1'b0);
    fmt = 2'b11; push(12'h789, 3'd1, 1'b0, 1'b0);
    fmt = 2'b10; push(12'h321, 3'd0, 1'b0, 1'b0);
    fmt = 2'b00;
    chk("R9 count 5", count, 5);
    pop_chk("R2 fmt00", 16'hABC0);
    chk("R9 count after pop", count, 4);
    pop_chk("R3 fmt01", 16'h1232);
    pop_chk("R4 fmt10", 16'h4563);
    pop_chk("R2 fmt11", 16'h7890);
    pop_chk("R4 fmt10 ch0", 16'h3211);
    chk("R10 empty count", count, 0);
    chk("R10 empty rd", rd_data, 0);
    pop = 1'b1; @(negedge clk); pop = 1'b0;
    chk("R10 pop on empty count", count, 0);
    chk("R10 pop on empty rd", rd_data, 0);
  endtask

  task automatic t_linear;
    set_mode(3'b110);
    chk("R11 flush on mode change", count, 0);
    for (int i = 0; i < 3; i++) push(12'h0F0 + 12'(i), 3'd0, 1'b0, 1'b0);
    chk("R5 post-alert waits", count, 0);
    push(12'h010, 3'd0, 1'b1, 1'b0);
    for (int i = 1; i < 20; i++) push(12'h010 + 12'(i), 3'd0, 1'b0, 1'b0);
    chk("R6 count 16", count, 16);
    chk("R6 full", full, 1);
    for (int i = 0; i < 16; i++) pop_chk("R6 R9 linear order", {12'h010 + 12'(i), 4'h0});
    chk("R6 drained", count, 0);
  endtask

  task automatic t_ring;
    set_mode(3'b000);
    for (int i = 0; i < 20; i++) push(12'h100 + 12'(i), 3'd0, 1'b0, 1'b0);
    chk("R7 count stays 16", count, 16);
    chk("R7 oldest overwritten", rd_data, 16'h1040);
    push(12'h200, 3'd0, 1'b1, 1'b0);
    push(12'h300, 3'd0, 1'b0, 1'b0);
    push(12'h301, 3'd0, 1'b0, 1'b0);
    chk("R8 frozen count", count, 16);
    for (int i = 5; i < 20; i++) pop_chk("R7 R8 ring order", {12'h100 + 12'(i), 4'h0});
    pop_chk("R8 trigger sample kept", 16'h2000);
    chk("R8 drained", count, 0);
  endtask

  task automatic t_prealert;
    set_mode(3'b100);
    push(12'h061, 3'd0, 1'b0, 1'b0);
    push(12'h062, 3'd0, 1'b0, 1'b0);
    push(12'h063, 3'd0, 1'b1, 1'b0);
    push(12'h064, 3'd0, 1'b0, 1'b0);
    chk("R8 pre-alert freeze count", count, 3);
    chk("R7 pre-alert oldest", rd_data, 16'h0610);
  endtask

  task automatic t_simul;
    set_mode(3'b000);
    for (int i = 0; i < 16; i++) push(12'h040 + 12'(i), 3'd0, 1'b0, 1'b0);
    chk("R7 full ring", full, 1);
    chk("R12 head before", rd_data, 16'h0400);
    push(12'h099, 3'd0, 1'b0, 1'b1);
    chk("R12 full pop+write count", count, 16);
    chk("R12 head after", rd_data, 16'h0410);
    set_mode(3'b001);
    chk("R11 flush to start-burst", count, 0);
    push(12'h0A1, 3'd0, 1'b1, 1'b0);
    push(12'h0A2, 3'd0, 1'b0, 1'b0);
    push(12'h0A3, 3'd0, 1'b0, 1'b0);
    push(12'h0A4, 3'd0, 1'b0, 1'b1);
    chk("R12 linear pop+write count", count, 3);
    chk("R12 linear head", rd_data, 16'h0A20);
  endtask

  task automatic t_reserved;
    set_mode(3'b010);
    chk("R11 flush to reserved", count, 0);
    push(12'h777, 3'd0, 1'b1, 1'b0);
    push(12'h778, 3'd0, 1'b0, 1'b0);
    chk("R11 reserved 010 stores nothing", count, 0);
    set_mode(3'b101);
    push(12'h779, 3'd0, 1'b1, 1'b0);
    chk("R11 reserved 101 stores nothing", count, 0);
    set_mode(3'b000);
    mode = 3'b100; res_valid = 1'b1; res_data = 12'h111;
    @(negedge clk);
    res_valid = 1'b0;
    chk("R11 change-cycle input dropped", count, 0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_formats();
    t_linear();
    t_ring();
    t_prealert();
    t_simul();
    t_reserved();
    done = 1;
    finish_run();
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule